// File: doc/BRIEF.md
# Strided indirect read port for per-ring state memories

This block gives software read access to several small per-ring state memories, each 16 entries deep, through one register address per memory. A control register holds an 8-bit entry pointer and an 8-bit stride. Reading any memory-backed address returns the entry that the pointer selects in that memory. The same read then advances the pointer by the stride. Software sets the pointer to 0 and the stride to 1, then issues consecutive reads to dump a memory in order. Other strides give sparse or interleaved dumps.

The memories stay with the ring engines that own them. Their contents come into the block as one flat state vector, and the block holds only the pointer, the stride and the read response register. Reads and writes use plain one-cycle strobes with separate addresses. Every read strobe gets a response one cycle later, and the response cannot be stalled, so the port has no back-pressure. The control register sits at address 0. The memories sit at consecutive addresses starting at `MEM_BASE`. Every other address is unmapped.

Top module: `ring_rdport`

## Requirements
- R1: After reset the pointer and the stride are both 0 and `rd_valid` is low. With a stride of 0, repeated memory reads return the same entry.
- R2: A write to the control address loads the pointer from `wr_data[7:0]` and the stride from `wr_data[15:8]`. Reading the control address returns the stride in bits [15:8] and the pointer in bits [7:0], and all higher bits read as zero.
- R3: A read of address `MEM_BASE+m` returns word `e` of memory `m`, where `e` is the pointer value at the read strobe. The word is taken from `ring_state[(m*16+e)*DATA_W +: DATA_W]`.
- R4: Each memory read replaces the pointer with (pointer + stride) mod 256. The new pointer is in place for a read strobe in the next cycle, so back-to-back reads walk through the memory.
- R5: A memory read whose pointer is 16 or more returns zero and raises no fault. The pointer still advances by the stride.
- R6: A read of the control address or of an unmapped address leaves the pointer unchanged. An unmapped read returns zero.
- R7: A write to any address other than the control address changes neither the pointer nor the stride.
- R8: `rd_valid` is high exactly in the cycle after each cycle with `rd_stb` high. `rd_data` carries the response in that cycle.
- R9: When a control write and a memory read fall in the same cycle, the read uses the old pointer and the written values take effect, with no stride added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Read strobe, one read per cycle high |
| rd_addr | input | ADDR_W | Read register address |
| wr_stb | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | DATA_W | Write data |
| ring_state | input | NUM_MEMS*ENTRIES*DATA_W | Flattened contents of all state memories |
| rd_valid | output | 1 | Read response valid, one cycle after the strobe |
| rd_data | output | DATA_W | Read response data |

## Verification
The hardest case to reach is a pointer that passes 255 and wraps while it is already outside the 16 valid entries. Another hard case is a control write that lands in the same cycle as a memory read. The stimulus programs a pointer of 250 with a stride of 3, which forces two zero reads and a wrap back to entry 0. A later test issues the write and the read together, then reads back the control register to see which update won.

// File: rtl/ring_rdport_pkg.sv
package ring_rdport_pkg;
  localparam int PTR_W = 8;

  typedef enum logic [1:0] {
    AK_NONE = 2'd0,
    AK_CTRL = 2'd1,
    AK_MEM  = 2'd2
  } addr_kind_e;

  typedef struct packed {
    logic [PTR_W-1:0] stride;
    logic [PTR_W-1:0] ptr;
  } ctrl_t;
endpackage

// File: rtl/ring_rdport_decode.sv
module ring_rdport_decode
  import ring_rdport_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_MEMS  = 3,
  parameter int MEM_BASE  = 8,
  parameter int CTRL_ADDR = 0,
  localparam int SEL_W    = (NUM_MEMS > 1) ? $clog2(NUM_MEMS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output addr_kind_e        kind,
  output logic [SEL_W-1:0]  sel
);
  int unsigned a;
  always_comb begin
    a    = int'(addr);
    kind = AK_NONE;
    sel  = '0;
    if (a == CTRL_ADDR) begin
      kind = AK_CTRL;
    end else if (a >= MEM_BASE && a < MEM_BASE + NUM_MEMS) begin
      kind = AK_MEM;
      sel  = SEL_W'(a - MEM_BASE);
    end
  end
endmodule

// File: rtl/ring_rdport_ptr.sv
module ring_rdport_ptr
  import ring_rdport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  ctrl_t            load_val,
  input  logic             advance,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] stride
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      stride <= '0;
    end else if (load) begin
      ptr    <= load_val.ptr;
      stride <= load_val.stride;
    end else if (advance) begin
      ptr    <= ptr + stride;
    end
  end
endmodule

// File: rtl/ring_rdport_mux.sv
module ring_rdport_mux
  import ring_rdport_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_MEMS = 3,
  parameter int ENTRIES  = 16,
  localparam int SEL_W   = (NUM_MEMS > 1) ? $clog2(NUM_MEMS) : 1,
  localparam int EIDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [NUM_MEMS*ENTRIES*DATA_W-1:0] state,
  input  logic [SEL_W-1:0]                   sel,
  input  logic [PTR_W-1:0]                   ptr,
  output logic [DATA_W-1:0]                  word
);
  logic [EIDX_W-1:0] eidx;
  logic              in_range;
  logic [DATA_W-1:0] per_mem [NUM_MEMS];

  assign eidx     = ptr[EIDX_W-1:0];
  assign in_range = (int'(ptr) < ENTRIES);

  for (genvar m = 0; m < NUM_MEMS; m++) begin : g_mem
    assign per_mem[m] = state[(m*ENTRIES + int'(eidx))*DATA_W +: DATA_W];
  end

  always_comb begin
    word = '0;
    if (in_range && int'(sel) < NUM_MEMS) word = per_mem[sel];
  end
endmodule

// File: rtl/ring_rdport.sv
module ring_rdport
  import ring_rdport_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_MEMS  = 3,
  parameter int ENTRIES   = 16,
  parameter int MEM_BASE  = 8,
  parameter int CTRL_ADDR = 0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rd_stb,
  input  logic [ADDR_W-1:0]                  rd_addr,
  input  logic                               wr_stb,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic [NUM_MEMS*ENTRIES*DATA_W-1:0] ring_state,
  output logic                               rd_valid,
  output logic [DATA_W-1:0]                  rd_data
);
  localparam int SEL_W = (NUM_MEMS > 1) ? $clog2(NUM_MEMS) : 1;

  addr_kind_e       rd_kind, wr_kind;
  logic [SEL_W-1:0] rd_sel, wr_sel_unused;
  logic [PTR_W-1:0] ptr, stride;
  logic [DATA_W-1:0] mem_word, resp;
  logic             load, advance;
  logic             wr_hi_unused;
  ctrl_t            load_val;

  ring_rdport_decode #(.ADDR_W(ADDR_W), .NUM_MEMS(NUM_MEMS), .MEM_BASE(MEM_BASE),
                       .CTRL_ADDR(CTRL_ADDR)) u_rd_dec (
    .addr(rd_addr), .kind(rd_kind), .sel(rd_sel));

  ring_rdport_decode #(.ADDR_W(ADDR_W), .NUM_MEMS(NUM_MEMS), .MEM_BASE(MEM_BASE),
                       .CTRL_ADDR(CTRL_ADDR)) u_wr_dec (
    .addr(wr_addr), .kind(wr_kind), .sel(wr_sel_unused));

  assign load         = wr_stb && (wr_kind == AK_CTRL);
  assign advance      = rd_stb && (rd_kind == AK_MEM);
  assign load_val     = ctrl_t'(wr_data[2*PTR_W-1:0]);
  assign wr_hi_unused = ^wr_data[DATA_W-1:2*PTR_W];

  ring_rdport_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .advance(advance), .ptr(ptr), .stride(stride));

  ring_rdport_mux #(.DATA_W(DATA_W), .NUM_MEMS(NUM_MEMS), .ENTRIES(ENTRIES)) u_mux (
    .state(ring_state), .sel(rd_sel), .ptr(ptr), .word(mem_word));

  always_comb begin
    unique case (rd_kind)
      AK_CTRL: resp = DATA_W'({stride, ptr});
      AK_MEM:  resp = mem_word;
      default: resp = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_stb;
      rd_data  <= rd_stb ? resp : '0;
    end
  end
endmodule

// File: rtl/ring_rdport_chk.sv
module ring_rdport_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_MEMS  = 3,
  parameter int ENTRIES   = 16,
  parameter int MEM_BASE  = 8,
  parameter int CTRL_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_lo,
  input logic [7:0]        ptr,
  input logic [7:0]        stride,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);
  logic rd_mem, wr_ctrl;
  assign rd_mem  = rd_stb && (int'(rd_addr) >= MEM_BASE) && (int'(rd_addr) < MEM_BASE + NUM_MEMS);
  assign wr_ctrl = wr_stb && (int'(wr_addr) == CTRL_ADDR);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);
  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mem && !wr_ctrl) |=> ptr == 8'($past(ptr) + $past(stride)));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_mem && !wr_ctrl) |=> $stable(ptr));
  assert_foreign_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !rd_mem) |=> ($stable(ptr) && $stable(stride)));
  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ptr == $past(wr_lo[7:0]) && stride == $past(wr_lo[15:8])));
  assert_oob_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mem && int'(ptr) >= ENTRIES) |=> rd_data == '0);
endmodule

bind ring_rdport ring_rdport_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_MEMS(NUM_MEMS), .ENTRIES(ENTRIES),
  .MEM_BASE(MEM_BASE), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_lo(wr_data[15:0]),
  .ptr(ptr), .stride(stride), .rd_valid(rd_valid), .rd_data(rd_data));

// File: tb/ring_rdport_tb_top.sv
module ring_rdport_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, DW = 32, NM = 3, NE = 16, MB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_stb = 1'b0, wr_stb = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NM*NE*DW-1:0] ring_state;
  logic rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0, failures = 0;
  logic [7:0] m_ptr = 8'd0, m_stride = 8'd0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_rdport #(.ADDR_W(AW), .DATA_W(DW), .NUM_MEMS(NM), .ENTRIES(NE), .MEM_BASE(MB),
                .CTRL_ADDR(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .ring_state(ring_state),
    .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic logic [DW-1:0] ent(int m, int e);
    return DW'(((m + 1) << 24) | (e << 16) | ((e * 37 + m * 11 + 5) & 16'hFFFF));
  endfunction

  function automatic logic [DW-1:0] model_read(logic [AW-1:0] a);
    if (a == 0) return DW'({m_stride, m_ptr});
    if (int'(a) >= MB && int'(a) < MB + NM) return (m_ptr < NE) ? ent(int'(a) - MB, int'(m_ptr)) : '0;
    return '0;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one read per call; consecutive calls give back-to-back strobes
  task automatic rd(logic [AW-1:0] a, string req);
    rd_stb = 1'b1; rd_addr = a;
    exp_q.push_back(model_read(a)); tag_q.push_back(req);
    if (int'(a) >= MB && int'(a) < MB + NM) m_ptr = m_ptr + m_stride;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    if (a == 0) begin m_ptr = d[7:0]; m_stride = d[15:8]; end
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wr_and_rd(logic [DW-1:0] d, logic [AW-1:0] ra, string req);
    wr_stb = 1'b1; wr_addr = '0; wr_data = d;
    rd_stb = 1'b1; rd_addr = ra;
    exp_q.push_back(model_read(ra)); tag_q.push_back(req);
    m_ptr = d[7:0]; m_stride = d[15:8];
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R8 actual=unexpected rd_valid expected=no response");
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < NM; m++)
      for (int e = 0; e < NE; e++)
        ring_state[(m*NE + e)*DW +: DW] = ent(m, e);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid low", {31'b0, rd_valid}, '0);
    rd(0, "R1 ctrl reset");
    rd(MB, "R1 stride0 first");
    rd(MB, "R1 stride0 repeat");
    wr(0, 32'hFFFF_0100);
    rd(0, "R2 ctrl readback");
    for (int e = 0; e < NE; e++) rd(MB + 1, "R3 R4 sequential dump");
    rd(MB + 2, "R5 pointer 16 reads zero");
    rd(0, "R5 R6 pointer advanced to 17");
    wr(0, 32'h0000_03FA);
    rd(MB, "R5 pointer 250");
    rd(MB + 1, "R5 pointer 253");
    rd(MB + 2, "R4 wrap to entry 0");
    rd(5, "R6 unmapped reads zero");
    rd(11, "R6 unmapped reads zero");
    rd(0, "R6 pointer held at 3");
    wr(MB, 32'h0000_FFFF);
    wr(7, 32'h0000_FFFF);
    rd(0, "R7 foreign writes ignored");
    wr(0, 32'h0000_0501);
    rd(MB, "R4 stride5 entry1");
    rd(MB, "R4 stride5 entry6");
    rd(MB + 2, "R4 stride5 entry11");
    rd(MB + 1, "R5 stride5 out of range");
    wr_and_rd(32'h0000_0102, MB + 1, "R9 read uses old pointer");
    rd(0, "R9 write wins");
    rd(MB + 1, "R9 new pointer used");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R8 actual=%0d pending expected=0 pending", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule